// File: doc/BRIEF.md
# Pipelined Weighted Bit-Sum Tree

This block takes a mask word and returns the total of a set of constant per-bit weights, counting only the bits of the mask that are 1. Each weight is fixed at build time through a parameter. The total is formed by a tree of registered adders. The first tree level adds pairs of gated weights, where a clear bit adds zero. Each later level adds pairs of partial sums from the level before. The tree is padded with zero leaves up to the next power of two.

A mask enters together with a valid flag. The total comes out a fixed number of clocks later, together with its own valid flag. The block can take a new mask on every clock, so a stream of masks gives a stream of totals in the same order. With the default 12-bit mask the tree has four levels, so the latency is four clocks. The mask width must be at least 3.

Top module: `wsum_tree`

## Requirements
- R1: Bit i of the mask has weight `WEIGHTS[i*W_WIDTH +: W_WIDTH]`. The default weights for bits 0 to 11 are 12, 16, 33, 40, 55, 61, 77, 90, 101, 130, 150 and 180. `out_sum` is the sum of the weights of the bits that are set.
- R2: The mask 12'b100000000101 gives a total of 225.
- R3: The mask with all 12 bits set gives 945. The 12-bit result width holds every possible total without overflow.
- R4: A mask with no bits set gives a total of 0.
- R5: `out_valid` rises exactly four rising clock edges after the edge that samples `in_valid` high. On that same edge `out_sum` carries the total for the mask sampled with it.
- R6: A new mask is accepted on every clock. Back-to-back inputs give back-to-back totals in input order.
- R7: A clock with `in_valid` low produces `out_valid` low four clocks later, whatever the mask holds.
- R8: A synchronous active-high reset clears `out_valid` and `out_sum` to 0 and discards every total still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_mask` as a real input |
| in_mask | input | N_BITS (12) | Mask of the bits to be summed |
| out_valid | output | 1 | Marks `out_sum` as a real result |
| out_sum | output | W_WIDTH+clog2(N_BITS) (12) | Weighted total |

## Verification
The hardest case to reach is a reset that arrives while every pipeline stage holds a valid partial sum. After reset, none of those sums may appear at the output. To reach it, the stimulus first drives an unbroken run of valid masks so that all four stages are full. It then asserts reset in the middle of that run and keeps driving valid masks during the reset clocks. The reference model drops every expectation that was in flight, and it expects only zero, invalid outputs until fresh inputs have passed through the tree. Walking single bits, the all-ones and empty masks, pseudo-random streams and idle gaps carrying nonzero masks cover the remaining requirements.

// File: rtl/wsum_tree.sv
module wsum_tree #(
  parameter int N_BITS  = 12,
  parameter int W_WIDTH = 8,
  parameter logic [N_BITS*W_WIDTH-1:0] WEIGHTS = {
    8'd180, 8'd150, 8'd130, 8'd101, 8'd90, 8'd77,
    8'd61,  8'd55,  8'd40,  8'd33,  8'd16, 8'd12},
  localparam int LAT   = $clog2(N_BITS),
  localparam int PAD   = 1 << LAT,
  localparam int SUM_W = W_WIDTH + LAT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [N_BITS-1:0] in_mask,
  output logic              out_valid,
  output logic [SUM_W-1:0]  out_sum
);

  logic [SUM_W-1:0] leaf [PAD];
  logic [LAT-1:0]   vld;

  for (genvar i = 0; i < PAD; i++) begin : g_leaf
    if (i < N_BITS) begin : g_real
      assign leaf[i] = in_mask[i] ? SUM_W'(WEIGHTS[i*W_WIDTH +: W_WIDTH]) : '0;
    end else begin : g_pad
      assign leaf[i] = '0;
    end
  end

  for (genvar l = 0; l < LAT; l++) begin : lvl
    localparam int CNT = PAD >> (l + 1);
    for (genvar i = 0; i < CNT; i++) begin : node
      logic [SUM_W-1:0] q;
      if (l == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) q <= '0;
          else     q <= leaf[2*i] + leaf[2*i+1];
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) q <= '0;
          else     q <= lvl[l-1].node[2*i].q + lvl[l-1].node[2*i+1].q;
      end
    end
  end

  always_ff @(posedge clk)
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], in_valid};

  assign out_valid = vld[LAT-1];
  assign out_sum   = lvl[LAT-1].node[0].q;

endmodule

// File: rtl/wsum_tree_chk.sv
module wsum_tree_chk #(
  parameter int N_BITS  = 12,
  parameter int W_WIDTH = 8,
  parameter logic [N_BITS*W_WIDTH-1:0] WEIGHTS = '0,
  localparam int LAT   = $clog2(N_BITS),
  localparam int SUM_W = W_WIDTH + LAT
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [N_BITS-1:0] in_mask,
  input logic              out_valid,
  input logic [SUM_W-1:0]  out_sum
);

  function automatic int total_w();
    int t = 0;
    for (int i = 0; i < N_BITS; i++) t += int'(WEIGHTS[i*W_WIDTH +: W_WIDTH]);
    return t;
  endfunction

  localparam int TOTAL = total_w();

  logic [LAT-1:0] v_p, z_p, f_p;

  always_ff @(posedge clk)
    if (rst) begin
      v_p <= '0; z_p <= '0; f_p <= '0;
    end else begin
      v_p <= {v_p[LAT-2:0], in_valid};
      z_p <= {z_p[LAT-2:0], in_valid && (in_mask == '0)};
      f_p <= {f_p[LAT-2:0], in_valid && (&in_mask)};
    end

  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_p[LAT-1]);

  a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_p[LAT-1]) |-> out_sum == '0);

  a_r3_full_total: assert property (@(posedge clk) disable iff (rst)
    (out_valid && f_p[LAT-1]) |-> int'(out_sum) == TOTAL);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(out_sum) <= TOTAL);

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_sum == '0));

endmodule

bind wsum_tree wsum_tree_chk #(
  .N_BITS(N_BITS), .W_WIDTH(W_WIDTH), .WEIGHTS(WEIGHTS)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_mask(in_mask),
  .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/wsum_tree_test.sv
module wsum_tree_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 12;
  localparam int LAT = 4;
  localparam int WT [NB] = '{12, 16, 33, 40, 55, 61, 77, 90, 101, 130, 150, 180};

  typedef struct {
    bit    v;
    bit    cmp;
    int    sum;
    string tag;
  } exp_t;

  logic          clk = 0;
  logic          rst = 1;
  logic          in_valid = 0;
  logic [NB-1:0] in_mask = '0;
  logic          out_valid;
  logic [11:0]   out_sum;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t q[$];

  wsum_tree uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mask(in_mask),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_sum(logic [NB-1:0] m);
    int s = 0;
    for (int i = 0; i < NB; i++) if (m[i]) s += WT[i];
    return s;
  endfunction

  task automatic load_reset_expect();
    exp_t e;
    q.delete();
    e.v = 0; e.cmp = 1; e.sum = 0; e.tag = "R8";
    for (int i = 0; i < LAT; i++) q.push_back(e);
  endtask

  task automatic apply(input bit v, input logic [NB-1:0] m, input string tag);
    exp_t e, n;
    e = q.pop_front();
    n_vec++;
    if (out_valid !== e.v || (e.cmp && int'(out_sum) != e.sum)) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b sum=%0d expected valid=%0b sum=%0d",
               e.tag, out_valid, out_sum, e.v, e.cmp ? e.sum : -1);
    end
    n.v = v; n.cmp = v; n.sum = ref_sum(m); n.tag = tag;
    q.push_back(n);
    in_valid = v;
    in_mask  = m;
    @(negedge clk);
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) apply(0, 12'hABC, "R7");
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    load_reset_expect();

    apply(1, 12'b100000000101, "R2");
    flush(6);
    apply(1, 12'hFFF, "R3");
    apply(1, 12'h000, "R4");
    flush(5);

    for (int i = 0; i < NB; i++) apply(1, NB'(1) << i, "R1");
    flush(5);

    apply(1, 12'h555, "R5");
    flush(5);

    lf = 12'h9E3;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
      apply(1, lf, "R6");
    end
    for (int i = 0; i < 20; i++) begin
      lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
      apply(lf[0], lf, lf[0] ? "R6" : "R7");
    end
    flush(5);

    for (int i = 0; i < 6; i++) apply(1, 12'hFFF - 12'(i), "R6");
    rst = 1;
    in_valid = 1;
    in_mask  = 12'h7F0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    load_reset_expect();
    apply(1, 12'h800, "R1");
    flush(6);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule